// File: doc/BRIEF.md
# Receiver Power-Transfer Packet Sequencer

This block decides which packet a wireless power receiver sends to the transmitter, and when it sends it. After reset it sends the compulsory opening sequence. It then offers a high-power handshake and waits a bounded time for a reply. After that it enters the transfer loop, where it watches five stop conditions. When a stop condition is true, it sends one end-power-transfer packet that carries the reason code, then goes quiet until the next reset.

Each packet goes to a downstream biphase encoder as a header byte and a one-byte payload, over a valid/ready interface. The encoder needs about a millisecond per byte at the link's bit rate, so it holds `pkt_ready` low while it is busy. The sequencer presents a packet by raising `pkt_valid`. It keeps the header and payload unchanged until a cycle in which `pkt_valid` and `pkt_ready` are both high. It may present the next packet in the cycle right after that acceptance. It never withdraws a packet it has presented. `low_power` is a plain status pin that reports the granted mode.

Top module: `pkt_sequencer`

## Requirements
- R1: While reset is held and just after it is released, `pkt_valid` is 0 and `low_power` is 1.
- R2: With no stop condition active at start-up, the first three packets are, in this order: header 0x01 with payload `SS_VAL`, header 0x51 with payload `CFG_VAL`, and header 0x71 with payload `ID_VAL`.
- R3: If any stop condition is active in the first cycle after reset, the first packet is an end-power-transfer packet (header 0x02) and the opening sequence is skipped.
- R4: The end-power-transfer payload is the reason code: 0x00 for adapter present, 0x01 for charge complete, 0x02 for internal fault, 0x03 for over-temperature and 0x04 for overvoltage.
- R5: When several stop conditions are true together, the lowest non-zero code wins. Code 0x00 is sent only when the adapter is the only active condition.
- R6: After the identification packet is accepted, a handshake packet (header 0x3A, payload 0x00) follows. If `hs_reply` is seen within `HS_WAIT` cycles after that handshake packet is accepted, `low_power` falls to 0.
- R7: If no reply comes within the window, `low_power` stays 1 and the transfer loop is entered.
- R8: While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid` stays high and the header and payload do not change.
- R9: A stop condition that appears while the opening sequence or handshake is in progress does not alter or abort it. The end-power-transfer packet follows once the transfer loop is reached.
- R10: After the end-power-transfer packet is accepted, `pkt_valid` stays 0 until reset, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adapter_on | input | 1 | Wired adapter present (reason 0x00) |
| chg_done | input | 1 | Charge complete (reason 0x01) |
| int_fault | input | 1 | Internal fault (reason 0x02) |
| over_temp | input | 1 | Over-temperature (reason 0x03) |
| over_volt | input | 1 | Rectifier overvoltage (reason 0x04) |
| hs_reply | input | 1 | Transmitter answered the high-power handshake |
| pkt_valid | output | 1 | Packet presented to the encoder |
| pkt_ready | input | 1 | Encoder can take a packet |
| pkt_header | output | 8 | Packet header byte |
| pkt_payload | output | 8 | Packet payload byte |
| low_power | output | 1 | 1 = low-power mode, 0 = high-power mode |

## Verification
A stop condition can rise while an opening packet is waiting for the encoder. The bench provokes this by raising over-temperature while the first packet is stalled with `pkt_ready` low. It then checks two things: that the stalled header and payload stay unchanged, and that the whole opening sequence and handshake still come out before the end packet with reason 0x03. The bench also raises several stop conditions in the same cycle and judges the priority by the single reason code that is sent.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam logic [7:0] HDR_SIG  = 8'h01;
  localparam logic [7:0] HDR_CFG  = 8'h51;
  localparam logic [7:0] HDR_ID   = 8'h71;
  localparam logic [7:0] HDR_END  = 8'h02;
  localparam logic [7:0] HDR_HAND = 8'h3A;

  typedef enum logic [3:0] {
    ST_START, ST_SIG, ST_CFG, ST_ID, ST_HAND, ST_WAIT, ST_MAIN, ST_END, ST_HALT
  } seq_state_t;
endpackage

// File: rtl/seq_reason_sel.sv
module seq_reason_sel (
  input  logic       adapter_on,
  input  logic       chg_done,
  input  logic       int_fault,
  input  logic       over_temp,
  input  logic       over_volt,
  output logic       any_stop,
  output logic [7:0] reason
);
  always_comb begin
    any_stop = adapter_on | chg_done | int_fault | over_temp | over_volt;
    if (chg_done)       reason = 8'h01;
    else if (int_fault) reason = 8'h02;
    else if (over_temp) reason = 8'h03;
    else if (over_volt) reason = 8'h04;
    else                reason = 8'h00;
  end
endmodule

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int WAIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(WAIT + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (run && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LAST);
endmodule

// File: rtl/seq_out_reg.sv
module seq_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] hdr_in,
  input  logic [W-1:0] pay_in,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] hdr,
  output logic [W-1:0] pay
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      hdr   <= '0;
      pay   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      hdr   <= hdr_in;
      pay   <= pay_in;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pkt_sequencer.sv
module pkt_sequencer #(
  parameter int         HS_WAIT = 16,
  parameter logic [7:0] SS_VAL  = 8'h80,
  parameter logic [7:0] CFG_VAL = 8'h14,
  parameter logic [7:0] ID_VAL  = 8'h21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adapter_on,
  input  logic       chg_done,
  input  logic       int_fault,
  input  logic       over_temp,
  input  logic       over_volt,
  input  logic       hs_reply,
  output logic       pkt_valid,
  input  logic       pkt_ready,
  output logic [7:0] pkt_header,
  output logic [7:0] pkt_payload,
  output logic       low_power
);
  import seq_pkg::*;

  seq_state_t st, st_nx;
  logic       any_stop, acc, load, tmr_clr, tmr_run, tmr_done, grant;
  logic [7:0] reason, ld_hdr, ld_pay;

  seq_reason_sel u_sel (
    .adapter_on(adapter_on), .chg_done(chg_done), .int_fault(int_fault),
    .over_temp(over_temp), .over_volt(over_volt),
    .any_stop(any_stop), .reason(reason)
  );

  seq_wait_timer #(.WAIT(HS_WAIT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run), .done(tmr_done)
  );

  seq_out_reg #(.W(8)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .hdr_in(ld_hdr), .pay_in(ld_pay),
    .ready(pkt_ready), .valid(pkt_valid), .hdr(pkt_header), .pay(pkt_payload)
  );

  assign acc = pkt_valid & pkt_ready;

  always_comb begin
    st_nx   = st;
    load    = 1'b0;
    ld_hdr  = '0;
    ld_pay  = '0;
    tmr_clr = 1'b0;
    tmr_run = 1'b0;
    grant   = 1'b0;
    case (st)
      ST_START: begin
        load = 1'b1;
        if (any_stop) begin
          ld_hdr = HDR_END; ld_pay = reason; st_nx = ST_END;
        end else begin
          ld_hdr = HDR_SIG; ld_pay = SS_VAL; st_nx = ST_SIG;
        end
      end
      ST_SIG: if (acc) begin
        load = 1'b1; ld_hdr = HDR_CFG; ld_pay = CFG_VAL; st_nx = ST_CFG;
      end
      ST_CFG: if (acc) begin
        load = 1'b1; ld_hdr = HDR_ID; ld_pay = ID_VAL; st_nx = ST_ID;
      end
      ST_ID: if (acc) begin
        load = 1'b1; ld_hdr = HDR_HAND; ld_pay = 8'h00; st_nx = ST_HAND;
      end
      ST_HAND: if (acc) begin
        tmr_clr = 1'b1; st_nx = ST_WAIT;
      end
      ST_WAIT: begin
        tmr_run = 1'b1;
        if (hs_reply) begin
          grant = 1'b1; st_nx = ST_MAIN;
        end else if (tmr_done) begin
          st_nx = ST_MAIN;
        end
      end
      ST_MAIN: if (any_stop) begin
        load = 1'b1; ld_hdr = HDR_END; ld_pay = reason; st_nx = ST_END;
      end
      ST_END: if (acc) st_nx = ST_HALT;
      default: st_nx = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_START;
      low_power <= 1'b1;
    end else begin
      st <= st_nx;
      if (grant) low_power <= 1'b0;
    end
  end
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       hs_reply,
  input logic       pkt_valid,
  input logic       pkt_ready,
  input logic [7:0] pkt_header,
  input logic [7:0] pkt_payload,
  input logic       low_power
);
  logic end_taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) end_taken <= 1'b0;
    else if (pkt_valid && pkt_ready && pkt_header == 8'h02) end_taken <= 1'b1;
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_header) && $stable(pkt_payload))); // R8

  AST_QUIET_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    end_taken |-> !pkt_valid); // R10

  AST_END_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_header == 8'h02) |-> (pkt_payload <= 8'h04)); // R4

  AST_GRANT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(low_power) |-> $past(hs_reply)); // R6

  AST_MODE_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(low_power)); // R7

  AST_HDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_header == 8'h01 || pkt_header == 8'h51 || pkt_header == 8'h71 ||
                   pkt_header == 8'h3A || pkt_header == 8'h02)); // R2
endmodule

bind pkt_sequencer seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .hs_reply(hs_reply), .pkt_valid(pkt_valid),
  .pkt_ready(pkt_ready), .pkt_header(pkt_header), .pkt_payload(pkt_payload),
  .low_power(low_power)
);

// File: tb/sim_pkt_sequencer.sv
`timescale 1ns/1ps
module sim_pkt_sequencer;
  localparam int HS_WAIT = 16;
  localparam logic [7:0] SS_VAL = 8'h80, CFG_VAL = 8'h14, ID_VAL = 8'h21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adapter_on = 0, chg_done = 0, int_fault = 0, over_temp = 0, over_volt = 0;
  logic hs_reply = 0, pkt_ready = 0;
  logic pkt_valid, low_power;
  logic [7:0] pkt_header, pkt_payload;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pkt_sequencer #(.HS_WAIT(HS_WAIT), .SS_VAL(SS_VAL), .CFG_VAL(CFG_VAL), .ID_VAL(ID_VAL)) u0 (
    .clk(clk), .rst_n(rst_n), .adapter_on(adapter_on), .chg_done(chg_done),
    .int_fault(int_fault), .over_temp(over_temp), .over_volt(over_volt),
    .hs_reply(hs_reply), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_header(pkt_header), .pkt_payload(pkt_payload), .low_power(low_power)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_conds();
    adapter_on = 0; chg_done = 0; int_fault = 0; over_temp = 0; over_volt = 0;
    hs_reply = 0; pkt_ready = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  // wait for a presented packet, check it, accept it on the next edge
  task automatic take_pkt(input string req, input logic [7:0] eh, input logic [7:0] ep);
    int n = 0;
    while (!pkt_valid && n < 200) begin @(negedge clk); n++; end
    check({req, " valid"}, pkt_valid, 1);
    check({req, " header"}, pkt_header, eh);
    check({req, " payload"}, pkt_payload, ep);
    pkt_ready = 1;
    @(posedge clk);
    @(negedge clk);
    pkt_ready = 0;
  endtask

  task automatic expect_quiet(input string req, input int cycles);
    int seen = 0;
    pkt_ready = 1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pkt_valid) seen++;
      chg_done = i[0]; over_volt = i[1];
    end
    check(req, seen, 0);
    clear_conds();
  endtask

  task automatic opening(input string req);
    take_pkt({req, " signal"}, 8'h01, SS_VAL);
    take_pkt({req, " config"}, 8'h51, CFG_VAL);
    take_pkt({req, " ident"}, 8'h71, ID_VAL);
    take_pkt({req, " handshake R6"}, 8'h3A, 8'h00);
  endtask

  task automatic t_reset();
    clear_conds();
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 valid in reset", pkt_valid, 0);
    check("R1 mode in reset", low_power, 1);
    rst_n = 1;
    check("R1 valid after release", pkt_valid, 0);
    check("R1 mode after release", low_power, 1);
  endtask

  task automatic t_no_reply();
    clear_conds(); do_reset();
    opening("R2");
    repeat (HS_WAIT + 4) @(negedge clk);
    check("R7 mode without reply", low_power, 1);
    check("R7 nothing sent in loop", pkt_valid, 0);
    over_temp = 1;
    take_pkt("R4 overtemp end", 8'h02, 8'h03);
    expect_quiet("R10 quiet after end", 30);
  endtask

  task automatic t_reply();
    clear_conds(); do_reset();
    opening("R2 reply run");
    @(negedge clk);
    hs_reply = 1;
    @(negedge clk);
    hs_reply = 0;
    check("R6 mode after reply", low_power, 0);
    adapter_on = 1; chg_done = 1; int_fault = 1;
    take_pkt("R5 mixed stop", 8'h02, 8'h01);
    check("R6 mode kept after end", low_power, 0);
  endtask

  task automatic t_stall_and_race();
    clear_conds(); do_reset();
    @(negedge clk);
    check("R8 first presented", pkt_valid, 1);
    over_temp = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R8 held valid", pkt_valid, 1);
      check("R9 header held", pkt_header, 8'h01);
      check("R8 payload held", pkt_payload, SS_VAL);
    end
    opening("R9 opening completes");
    take_pkt("R9 end after loop", 8'h02, 8'h03);
  endtask

  task automatic t_immediate(input string req, input logic a, input logic f,
                             input logic v, input logic [7:0] code);
    clear_conds();
    adapter_on = a; int_fault = f; over_volt = v;
    do_reset();
    take_pkt(req, 8'h02, code);
    expect_quiet("R10 quiet after immediate end", 10);
  endtask

  task automatic t_loop_code(input string req, input logic a, input logic f,
                             input logic v, input logic [7:0] code);
    clear_conds(); do_reset();
    opening("R2 loop run");
    repeat (HS_WAIT + 4) @(negedge clk);
    adapter_on = a; int_fault = f; over_volt = v;
    take_pkt(req, 8'h02, code);
  endtask

  initial begin
    t_reset();
    t_no_reply();
    t_reply();
    t_stall_and_race();
    t_immediate("R3 adapter at start R4", 1, 0, 0, 8'h00);
    t_immediate("R3 adapter with fault R5", 1, 1, 0, 8'h02);
    t_loop_code("R5 fault beats overvolt", 0, 1, 1, 8'h02);
    t_loop_code("R4 overvolt alone", 0, 0, 1, 8'h04);
    t_loop_code("R5 overvolt beats adapter", 1, 0, 1, 8'h04);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule